// File: doc/BRIEF.md
# SD Card Data Word FIFO

This block is the word buffer that sits between a host controller's data register and the serial data path of an SD card interface. It holds up to sixteen 32-bit words and serves both transfer directions. When a card read is in progress, the data path deposits words and software drains them through the data register. When a card write is in progress, software deposits words and the data path drains them.

The block reports its live occupancy, and it compares that occupancy with two programmable 5-bit levels, one for each direction. The comparison tells the data path when a read burst is ready for software or when enough write data has been buffered to start sending. A push into a full buffer or a pop from an empty one raises a sticky error flag, which software clears on purpose.

Top module: `sd_data_fifo`

## Requirements
- R1: After reset, the fill level is 0, the error flag is low, the head word is zero, and both threshold outputs follow only from a fill level of 0.
- R2: Words leave in the order they entered. Capacity is 16 words. The fill level goes up by one on each accepted push and down by one on each accepted pop.
- R3: A push while the buffer holds 16 words and no pop is requested is dropped. The stored words and the fill level stay unchanged, and the error flag is set on the next cycle.
- R4: A pop while the buffer is empty changes nothing and sets the error flag on the next cycle. While the buffer is empty, the head word reads as zero.
- R5: With `dir_rd`=1 (card read), only `dp_push` adds words and only `reg_rd_en` removes them. With `dir_rd`=0 (card write), only `reg_wr_en` adds words and only `dp_pop` removes them. Requests from the inactive side have no effect.
- R6: A push and a pop in the same cycle on a non-empty buffer are both accepted and leave the fill level unchanged. This holds even when the buffer is full.
- R7: `data_ready` is high exactly when `dir_rd`=1 and the fill level is at least `rd_thresh`.
- R8: `send_go` is high exactly when `dir_rd`=0 and the fill level is at least `wr_thresh`.
- R9: The error flag stays set until a cycle with `err_clr` high. If a new overflow or underflow happens in the same cycle as `err_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rd | input | 1 | 1: card read transfer, 0: card write transfer |
| reg_wr_en | input | 1 | Register-side write of a word |
| reg_wr_data | input | 32 | Word written from the register side |
| reg_rd_en | input | 1 | Register-side read (consumes head word) |
| dp_push | input | 1 | Data-path push of a received word |
| dp_push_data | input | 32 | Word pushed by the data path |
| dp_pop | input | 1 | Data-path pop of a word to send |
| head_data | output | 32 | Oldest stored word, zero when empty |
| rd_thresh | input | 5 | Read-direction ready level |
| wr_thresh | input | 5 | Write-direction start level |
| err_clr | input | 1 | Clears the sticky error flag |
| fill_level | output | 5 | Words currently held (0 to 16) |
| fifo_err | output | 1 | Sticky overflow/underflow flag |
| data_ready | output | 1 | Read burst available for software |
| send_go | output | 1 | Enough write data buffered to send |

## Verification
The properties assume that `dir_rd` and the two thresholds are quasi-static configuration, and that a cleared error can be set again in the same cycle as the clear. Beyond that, they accept any combination of push and pop requests, including requests from the inactive side. The stimulus changes direction and thresholds only between bursts. On purpose, it drives both sides at once, pushes into a full buffer, pops from an empty one, and lines a clear up with a fresh error. This way the assumed corners are actually visited rather than avoided.

// File: rtl/sd_data_fifo.sv
module sd_data_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rd,
  input  logic             reg_wr_en,
  input  logic [WIDTH-1:0] reg_wr_data,
  input  logic             reg_rd_en,
  input  logic             dp_push,
  input  logic [WIDTH-1:0] dp_push_data,
  input  logic             dp_pop,
  output logic [WIDTH-1:0] head_data,
  input  logic [CNT_W-1:0] rd_thresh,
  input  logic [CNT_W-1:0] wr_thresh,
  input  logic             err_clr,
  output logic [CNT_W-1:0] fill_level,
  output logic             fifo_err,
  output logic             data_ready,
  output logic             send_go
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             err;

  wire             push_req  = dir_rd ? dp_push : reg_wr_en;
  wire [WIDTH-1:0] push_word = dir_rd ? dp_push_data : reg_wr_data;
  wire             pop_req   = dir_rd ? reg_rd_en : dp_pop;
  wire             empty     = (cnt == '0);
  wire             full      = (cnt == CNT_W'(DEPTH));
  wire             pop_ok    = pop_req && !empty;
  wire             push_ok   = push_req && (!full || pop_req);
  wire             bad       = (pop_req && empty) || (push_req && !push_ok);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (bad)          err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  assign head_data  = empty ? '0 : mem[rp];
  assign fill_level = cnt;
  assign fifo_err   = err;
  assign data_ready = dir_rd && (cnt >= rd_thresh);
  assign send_go    = !dir_rd && (cnt >= wr_thresh);
endmodule

// File: rtl/sd_data_fifo_chk.sv
module sd_data_fifo_chk #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_rd,
  input logic             reg_wr_en,
  input logic             reg_rd_en,
  input logic             dp_push,
  input logic             dp_pop,
  input logic             err_clr,
  input logic [WIDTH-1:0] head_data,
  input logic [CNT_W-1:0] fill_level,
  input logic             fifo_err,
  input logic             data_ready,
  input logic             send_go
);
  wire push_req = dir_rd ? dp_push : reg_wr_en;
  wire pop_req  = dir_rd ? reg_rd_en : dp_pop;
  wire at_full  = (fill_level == CNT_W'(DEPTH));
  wire at_empty = (fill_level == '0);

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(DEPTH));

  p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == $past(fill_level)) || (fill_level == $past(fill_level) + 1'b1) ||
    (fill_level + 1'b1 == $past(fill_level)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !pop_req && at_full |=> fifo_err && (fill_level == CNT_W'(DEPTH)));

  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && at_empty |=> fifo_err);

  p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    at_empty |-> head_data == '0);

  p_both_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && pop_req && !at_empty |=> $stable(fill_level));

  p_ready_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_rd |-> !data_ready);

  p_go_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rd |-> !send_go);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err && !err_clr |=> fifo_err);
endmodule

bind sd_data_fifo sd_data_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .reg_wr_en(reg_wr_en),
  .reg_rd_en(reg_rd_en), .dp_push(dp_push), .dp_pop(dp_pop), .err_clr(err_clr),
  .head_data(head_data), .fill_level(fill_level), .fifo_err(fifo_err),
  .data_ready(data_ready), .send_go(send_go)
);

// File: tb/test_sd_data_fifo.sv
module test_sd_data_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_rd = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0, dp_push = 1'b0, dp_pop = 1'b0, err_clr = 1'b0;
  logic [31:0] reg_wr_data = '0, dp_push_data = '0;
  logic [4:0]  rd_thresh = 5'd4, wr_thresh = 5'd4;
  logic [31:0] head_data;
  logic [4:0]  fill_level;
  logic        fifo_err, data_ready, send_go;

  int total = 0, failed = 0;
  bit done = 0;
  logic [31:0] q[$];
  bit merr = 0;

  always #10 clk = ~clk;

  sd_data_fifo i_sd_data_fifo (
    .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .dp_push(dp_push),
    .dp_push_data(dp_push_data), .dp_pop(dp_pop), .head_data(head_data),
    .rd_thresh(rd_thresh), .wr_thresh(wr_thresh), .err_clr(err_clr),
    .fill_level(fill_level), .fifo_err(fifo_err), .data_ready(data_ready),
    .send_go(send_go)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int n = q.size();
    chk(tag, "fill", 32'(fill_level), 32'(n));
    chk(tag, "err", 32'(fifo_err), 32'(merr));
    chk(tag, "head", head_data, n > 0 ? q[0] : 32'h0);
    chk({tag, "/R7"}, "ready", 32'(data_ready), 32'(dir_rd && n >= int'(rd_thresh)));
    chk({tag, "/R8"}, "go", 32'(send_go), 32'(!dir_rd && n >= int'(wr_thresh)));
  endtask

  task automatic step(input string tag, input bit rw, input bit rr, input bit pu, input bit po,
                      input bit clr, input logic [31:0] wd);
    bit pushr, popr, pop_ok, push_ok, bad;
    logic [31:0] word;
    reg_wr_en = rw; reg_rd_en = rr; dp_push = pu; dp_pop = po; err_clr = clr;
    reg_wr_data = wd; dp_push_data = wd;
    #1 compare(tag);
    pushr = dir_rd ? pu : rw;
    popr  = dir_rd ? rr : po;
    word  = wd;
    pop_ok  = popr && q.size() > 0;
    push_ok = pushr && (q.size() < 16 || popr);
    bad = (popr && q.size() == 0) || (pushr && !push_ok);
    @(posedge clk);
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(word);
    if (bad) merr = 1; else if (clr) merr = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0);

    // R5 write direction: register side fills
    dir_rd = 1'b0; wr_thresh = 5'd4;
    for (int i = 0; i < 16; i++) step("R2", 1, 0, 0, 0, 0, 32'hA000_0000 + i);
    step("R5", 0, 1, 1, 0, 0, 32'h1111_1111);   // inactive side: read and dp push
    step("R5", 0, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 0, 32'hDEAD_BEEF);   // overflow
    step("R3", 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 1, 0);
    step("R6", 1, 0, 0, 1, 0, 32'hB000_0001);   // both at full
    step("R6", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) step("R2", 0, 0, 0, 1, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 0);               // underflow
    step("R4", 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 1, 1, 0);               // set wins over clear
    step("R9", 0, 0, 0, 0, 1, 0);
    step("R6", 1, 0, 0, 1, 0, 32'hC000_0000);   // both at empty: push only
    step("R6", 1, 0, 0, 1, 0, 32'hC000_0001);
    step("R6", 0, 0, 0, 1, 1, 0);
    step("R6", 0, 0, 0, 0, 0, 0);

    // read direction: data path fills, register side drains
    dir_rd = 1'b1; rd_thresh = 5'd4;
    for (int i = 0; i < 6; i++) step("R7", 0, 0, 1, 0, 0, 32'h5000_0000 + i * 3);
    step("R5", 1, 0, 0, 1, 0, 32'h7777_7777);   // inactive side: write and dp pop
    step("R5", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R2", 0, 1, 0, 0, 0, 0);
    rd_thresh = 5'd0;
    step("R7", 0, 0, 0, 0, 0, 0);
    rd_thresh = 5'd16;
    for (int i = 0; i < 16; i++) step("R7", 0, 0, 1, 0, 0, 32'h9000_0000 ^ (i << 8));
    step("R7", 0, 0, 1, 0, 0, 32'hFFFF_FFFF);   // overflow from data path
    step("R3", 0, 1, 1, 0, 1, 32'h1234_5678);   // both at full, clear
    dir_rd = 1'b0; wr_thresh = 5'd0;
    step("R8", 0, 0, 0, 0, 0, 0);
    wr_thresh = 5'd16;
    step("R8", 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule